// File: doc/BRIEF.md
# Conditional PC-Relative Branch Resolver

This block resolves a short conditional branch for a 16-bit processor. In each instruction slot it takes the current program counter and a 4-bit condition selector. It also takes a 7-bit signed displacement, the six status flags (C, Z, N, V, U, E) and a mode bit that permits the unsigned-compare conditions. From these it decides whether the branch is taken, works out the following program counter, and reports an illegal use. The program counter is held inside the block and is loaded with the resolved value on every cycle in which the instruction strobe is high.

Three cases make a use illegal:

- the selector is a reserved code, or an unsigned-compare condition is selected while the mode bit is clear;
- the branch sits at the last or second-to-last address of an active loop;
- a repeat is in progress.

An illegal branch is never taken. The program counter then moves to the next sequential address.

The selector codes 0 and 1 also serve as the unsigned higher-or-same and lower aliases. Because the hardware test is the same, they stay legal in either mode. Only codes 8 and 9, which need the combined carry-or-zero test, depend on the mode bit.

Top module: `branch_resolver`

## Requirements
- R1: While `rst_n` is low the program counter `pc` is cleared to 0. With `instr_valid` low, `taken` and `illegal` are 0.
- R2: A taken branch sets `next_pc` to `pc + 1 + offset`. Here `offset` is a 7-bit two's-complement value, sign-extended to 16 bits, and the sum wraps modulo 2^16.
- R3: A branch that is not taken sets `next_pc` to `pc + 1`, which also wraps modulo 2^16.
- R4: Selector code 0 is taken when C=0 and code 1 when C=1. Code 2 is taken when Z=1 and code 3 when Z=0.
- R5: Selector code 4 is taken when N^V=0 and code 5 when N^V=1. Code 6 is taken when Z|(N^V)=0 and code 7 when Z|(N^V)=1.
- R6: Selector code 8 is taken when C|Z=0 and code 9 when C|Z=1. Both codes require `unsigned_alias_en`=1; with that input at 0 they are illegal.
- R7: Selector code 10 is taken when Z|(~U&~E)=0 and code 11 when Z|(~U&~E)=1.
- R8: Selector codes 12 to 15 are reserved and always illegal.
- R9: When `loop_active` is 1 and `pc` equals `loop_end` or `loop_end - 1`, the branch is illegal. Any other `pc`, or `loop_active` at 0, leaves the branch legal.
- R10: A branch with `repeat_active` at 1 is illegal.
- R11: When `illegal` is 1, `taken` is 0 and `next_pc` is `pc + 1`.
- R12: `pc` loads `next_pc` on a rising clock edge with `instr_valid` at 1. With `instr_valid` at 0, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A branch is resolved in this cycle |
| cond_sel | input | 4 | Condition selector code |
| offset | input | 7 | Signed branch displacement |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_u | input | 1 | Unnormalized flag |
| flag_e | input | 1 | Extension flag |
| unsigned_alias_en | input | 1 | Permits the unsigned-compare codes 8 and 9 |
| loop_active | input | 1 | A hardware loop is running |
| loop_end | input | 16 | Last address of the running loop |
| repeat_active | input | 1 | A repeat is in progress |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Resolved following program counter |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Illegal branch use |

## Verification
The bench drives a backward branch from address 0 so that the target wraps to 0xFFFF, and then a forward branch from 0xFFFF. A design that left out the sign extension, or the +1 for the next instruction, would land at the wrong address. It places `pc` exactly on `loop_end`, on `loop_end - 1` and on `loop_end + 1`, and toggles `loop_active`. An off-by-one window would then flag a legal branch or miss an illegal one. It also sends codes 8 and 9 with the mode bit clear, the reserved codes, and branches made under repeat, each with flags that would otherwise make the condition true. A design that let an illegal branch through would jump instead of stepping by one.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [3:0]       cond_sel,
  input  logic [OFF_W-1:0] offset,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic             flag_u,
  input  logic             flag_e,
  input  logic             unsigned_alias_en,
  input  logic             loop_active,
  input  logic [PC_W-1:0]  loop_end,
  input  logic             repeat_active,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic             illegal
);
  localparam int EXT_W = PC_W - OFF_W;

  logic cond_true;
  logic bad;

  wire [PC_W-1:0] seq_pc  = pc + PC_W'(1);
  wire [PC_W-1:0] off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  wire [PC_W-1:0] tgt_pc  = seq_pc + off_ext;
  wire            nxv     = flag_n ^ flag_v;
  wire            norm    = flag_z | (~flag_u & ~flag_e);

  always_comb begin
    case (cond_sel)
      4'd0:    cond_true = ~flag_c;
      4'd1:    cond_true = flag_c;
      4'd2:    cond_true = flag_z;
      4'd3:    cond_true = ~flag_z;
      4'd4:    cond_true = ~nxv;
      4'd5:    cond_true = nxv;
      4'd6:    cond_true = ~(flag_z | nxv);
      4'd7:    cond_true = flag_z | nxv;
      4'd8:    cond_true = ~(flag_c | flag_z);
      4'd9:    cond_true = flag_c | flag_z;
      4'd10:   cond_true = ~norm;
      4'd11:   cond_true = norm;
      default: cond_true = 1'b0;
    endcase
  end

  wire sel_bad   = cond_sel > 4'd11;
  wire alias_bad = (cond_sel == 4'd8 || cond_sel == 4'd9) && !unsigned_alias_en;
  wire loop_bad  = loop_active && (pc == loop_end || pc == loop_end - PC_W'(1));

  assign bad     = sel_bad | alias_bad | loop_bad | repeat_active;
  assign illegal = instr_valid & bad;
  assign taken   = instr_valid & cond_true & ~bad;
  assign next_pc = (cond_true & ~bad) ? tgt_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n)           pc <= '0;
    else if (instr_valid) pc <= next_pc;
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [3:0]       cond_sel,
  input logic [OFF_W-1:0] offset,
  input logic             repeat_active,
  input logic [PC_W-1:0]  pc,
  input logic             taken,
  input logic             illegal
);
  wire [PC_W-1:0] off_x = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !taken); // R11
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc)); // R12
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !taken |=> pc == $past(pc) + PC_W'(1)); // R3
  AST_PC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && taken |=> pc == $past(pc) + PC_W'(1) + $past(off_x)); // R2
  AST_REPEAT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && repeat_active |-> illegal); // R10
  AST_RESERVED_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && cond_sel > 4'd11 |-> illegal && !taken); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !taken && !illegal); // R1
endmodule

bind branch_resolver branch_resolver_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [3:0] cond_sel = 0;
  logic [6:0] offset = 0;
  logic flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0, flag_u = 0, flag_e = 0;
  logic unsigned_alias_en = 0, loop_active = 0, repeat_active = 0;
  logic [15:0] loop_end = 0;
  logic [15:0] pc, next_pc;
  logic taken, illegal;

  int total = 0, bad = 0;
  logic [15:0] model_pc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_resolver u_dut (.*);

  function automatic logic cond_eval(input logic [3:0] s, input logic [5:0] f);
    logic c, z, n, v, u, e;
    {c, z, n, v, u, e} = f;
    case (s)
      0: return c == 0;          1: return c == 1;
      2: return z == 1;          3: return z == 0;
      4: return (n != v) == 0;   5: return (n != v) == 1;
      6: return !z && n == v;    7: return z || n != v;
      8: return !c && !z;        9: return c || z;
      10: return !(z || (!u && !e));
      11: return z || (!u && !e);
      default: return 0;
    endcase
  endfunction

  function automatic logic illegal_eval(input logic [3:0] s, input logic m, input logic la,
                                        input logic [15:0] le, input logic rp, input logic [15:0] p);
    return s >= 12 || ((s == 8 || s == 9) && !m) ||
           (la && (p == le || p + 16'd1 == le)) || rp;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [3:0] s, input logic [6:0] off,
                      input logic [5:0] f, input logic m, input logic la,
                      input logic [15:0] le, input logic rp);
    logic exp_ill, exp_tk;
    logic [15:0] exp_nx;
    @(negedge clk);
    instr_valid = v; cond_sel = s; offset = off;
    {flag_c, flag_z, flag_n, flag_v, flag_u, flag_e} = f;
    unsigned_alias_en = m; loop_active = la; loop_end = le; repeat_active = rp;
    #1;
    exp_ill = illegal_eval(s, m, la, le, rp, model_pc);
    exp_tk  = !exp_ill && cond_eval(s, f);
    exp_nx  = exp_tk ? model_pc + 16'd1 + {{9{off[6]}}, off} : model_pc + 16'd1;
    check({tag, " taken"},   {15'd0, taken},   {15'd0, v & exp_tk});
    check({tag, " illegal"}, {15'd0, illegal}, {15'd0, v & exp_ill});
    check({tag, " next_pc"}, next_pc, exp_nx);
    @(posedge clk); #1;
    if (v) model_pc = exp_nx;
    check({tag, " pc"}, pc, model_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pc", pc, 16'd0);
    check("R1 reset taken", {15'd0, taken}, 16'd0);
    check("R1 reset illegal", {15'd0, illegal}, 16'd0);
    @(negedge clk); rst_n = 1;

    // R2 wrap backward then forward across 0xFFFF
    step("R2 wrap back", 1, 4'd2, 7'h7E, 6'b010000, 0, 0, 0, 0);
    check("R2 at FFFF", pc, 16'hFFFF);
    step("R2 wrap fwd", 1, 4'd3, 7'd3, 6'b000000, 0, 0, 0, 0);
    check("R2 at 3", pc, 16'd3);
    // R3 not taken, R12 hold
    step("R3 not taken", 1, 4'd0, 7'd20, 6'b100000, 0, 0, 0, 0);
    step("R12 hold", 0, 4'd0, 7'd20, 6'b000000, 0, 0, 0, 0);
    // R4 R5 R7 directed
    step("R4 cs", 1, 4'd1, 7'd5, 6'b100000, 0, 0, 0, 0);
    step("R5 gt", 1, 4'd6, 7'd2, 6'b001100, 0, 0, 0, 0);
    step("R5 lt", 1, 4'd5, 7'h70, 6'b000100, 0, 0, 0, 0);
    step("R7 nr", 1, 4'd11, 7'd4, 6'b000000, 0, 0, 0, 0);
    step("R7 nn", 1, 4'd10, 7'd4, 6'b000010, 0, 0, 0, 0);
    // R6 mode gating
    step("R6 hi mode off", 1, 4'd8, 7'd9, 6'b000000, 0, 0, 0, 0);
    step("R6 ls mode off", 1, 4'd9, 7'd9, 6'b110000, 0, 0, 0, 0);
    step("R6 hi mode on", 1, 4'd8, 7'd9, 6'b000000, 1, 0, 0, 0);
    // R8 reserved
    for (int s = 12; s < 16; s++) step("R8 reserved", 1, 4'(s), 7'd9, 6'b111111, 1, 0, 0, 0);
    // R9 loop window edges
    step("R9 at end", 1, 4'd3, 7'd8, 6'b000000, 0, 1, model_pc, 0);
    step("R9 at end-1", 1, 4'd3, 7'd8, 6'b000000, 0, 1, model_pc + 16'd1, 0);
    step("R9 at end+1", 1, 4'd3, 7'd8, 6'b000000, 0, 1, model_pc - 16'd1, 0);
    step("R9 loop off", 1, 4'd3, 7'd8, 6'b000000, 0, 0, model_pc, 0);
    // R10 R11 repeat
    step("R10 repeat", 1, 4'd3, 7'd8, 6'b000000, 1, 0, 0, 1);
    step("R11 illegal step", 1, 4'd0, 7'd30, 6'b000000, 1, 0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      logic [15:0] le;
      s  = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
      le = ($urandom % 4 == 0) ? model_pc + 16'($urandom % 3) : 16'($urandom);
      step("R2 R3 random", ($urandom % 5) != 0, s, 7'($urandom), 6'($urandom),
           1'($urandom), ($urandom % 3) == 0, le, ($urandom % 10) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule